// File: doc/BRIEF.md
# Instruction Fetch Aligner with Decode Queue

This block is the fetch stage of a four-wide in-order core. Each cycle it receives the whole 64-byte instruction cache line that holds the current fetch address. The line holds sixteen 32-bit instructions. With the line come one predicted-taken flag per slot and a single predicted target address. From these inputs the block cuts out a fetch group of one to four consecutive instructions. The group starts at the fetch address. It stops early at the end of the line, or just after the first slot that is predicted taken.

The instructions in a group, each paired with its address, go into an 18-entry circular queue. The decode stage reads that queue. Decode may take zero, one or two entries from the head each cycle. The queue lets fetch run ahead of decode, so that short groups in one cycle are covered by full groups in others. The block then selects the next fetch address: the predicted target, the sequential address, or the current address again when the group does not fit.

A redirect from the back end, raised after a branch mispredict, empties the queue. It also moves fetch to the corrected address. The instruction cache and the branch predictor are outside this block.

Top module: `fetch_align_queue`

## Requirements
- R1: After a synchronous active-low reset, `fetch_pc` equals the `RESET_PC` parameter (default 0) and `dq_valid` is all zero.
- R2: The slot of the fetch address is `fetch_pc[5:2]`, and slot s is `blk_data[32*s +: 32]`. When the slot is 12 or lower and none of the four slots from the fetch slot onward is flagged in `pred_taken`, four instructions are queued. Their addresses are `fetch_pc`, `fetch_pc`+4, `fetch_pc`+8 and `fetch_pc`+12, and the next `fetch_pc` is `fetch_pc`+16.
- R3: A group never runs past slot 15. When the fetch slot is 13, 14 or 15, the group holds 16 minus that slot instructions, so slot 15 gives a single instruction. The next address is the fetch address plus four times the group size.
- R4: `pred_taken` bit s flags slot s. The group ends at the first flagged slot within the group window, and that slot is included. The next `fetch_pc` is `pred_target`. Flags on slots before the fetch slot, or beyond the window, have no effect.
- R5: A group is queued only if the free space (18 minus the entries held at the start of the cycle) is at least the group size. Otherwise nothing is queued and `fetch_pc` keeps its value.
- R6: `dq_valid` is a thermometer code over the two head entries. `dq_word[0]` and `dq_pc[0]` give the oldest entry and lane 1 gives the next one. `deq_req` removes min(`deq_req`, entries held) entries, and a request of 3 acts as 2.
- R7: When `redirect_valid` is high, the next cycle shows an empty queue and `fetch_pc` equal to `redirect_pc`. The group offered in that cycle is not queued.
- R8: The queue holds up to 18 entries and accepts groups that fill it exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_data | input | 512 | Cache line holding `fetch_pc`; slot s at bits 32*s+31:32*s |
| pred_taken | input | 16 | Predicted-taken flag per line slot |
| pred_target | input | 32 | Predicted target of the taken slot |
| redirect_valid | input | 1 | Mispredict redirect: flush and restart |
| redirect_pc | input | 32 | Corrected fetch address |
| deq_req | input | 2 | Number of head entries decode consumes this cycle |
| fetch_pc | output | 32 | Current fetch address |
| dq_valid | output | 2 | Head lane valid flags |
| dq_word | output | 2x32 | Head lane instruction words |
| dq_pc | output | 2x32 | Head lane instruction addresses |

## Verification
The hardest case to reach is a queue that holds exactly 18 entries. Full groups of four only add up to multiples of four, so with no draining the queue stops at 16 and never fills. The stimulus therefore redirects to slot 2 of a line with decode idle. Three full groups are followed by a two-instruction group cut at the line boundary, and then another full group fills the last four places. A long random phase follows, with random redirects, taken flags and dequeue counts. It keeps the queue near full, so stalls and wrap-around of the circular pointers happen often. A behavioural model is compared with the outputs every cycle throughout.

// File: rtl/fa_pkg.sv
// Shared types for the fetch aligner.
// Assumes 32-bit addresses and 32-bit fixed-length instructions.
package fa_pkg;
    localparam int FA_XLEN = 32;

    // One queue entry: instruction address and instruction word
    typedef struct packed {
        logic [FA_XLEN-1:0] pc;
        logic [FA_XLEN-1:0] word;
    } fa_entry_t;
endpackage

// File: rtl/fa_group_select.sv
// Fetch group selection.
// Finds how many instructions, starting at the fetch slot, form this
// cycle's group: at most FETCH_W, never past the last line slot, and
// ending with the first predicted-taken slot. Also gives the lane words,
// the lane addresses and the next fetch address if the group is accepted.
// Assumes XLEN/8-byte aligned instructions and BLK_SLOTS a power of two.
module fa_group_select #(
    parameter int XLEN      = 32,
    parameter int BLK_SLOTS = 16,
    parameter int FETCH_W   = 4,
    localparam int SLOT_W   = $clog2(BLK_SLOTS),
    localparam int OFF_W    = $clog2(XLEN / 8),
    localparam int SZ_W     = $clog2(FETCH_W + 1)
) (
    input  logic [XLEN-1:0]                  fetch_pc,
    input  logic [BLK_SLOTS*XLEN-1:0]        blk_data,
    input  logic [BLK_SLOTS-1:0]             pred_taken,
    input  logic [XLEN-1:0]                  pred_target,
    output logic [SZ_W-1:0]                  grp_size,
    output logic                             grp_taken,
    output logic [XLEN-1:0]                  grp_next_pc,
    output logic [FETCH_W-1:0][XLEN-1:0]     lane_word,
    output logic [FETCH_W-1:0][XLEN-1:0]     lane_pc
);
    logic [SLOT_W-1:0] slot;
    logic              stop;
    logic [SLOT_W:0]   idx;

    assign slot = fetch_pc[OFF_W +: SLOT_W];

    // Scan the window: count slots up to the line end or first taken flag
    always_comb begin
        grp_size  = '0;
        grp_taken = 1'b0;
        stop      = 1'b0;
        idx       = '0;
        for (int i = 0; i < FETCH_W; i++) begin
            idx = {1'b0, slot} + (SLOT_W + 1)'(i);
            if (!stop) begin
                if (idx < (SLOT_W + 1)'(BLK_SLOTS)) begin
                    grp_size = SZ_W'(i + 1);
                    if (pred_taken[idx[SLOT_W-1:0]]) begin
                        grp_taken = 1'b1;
                        stop      = 1'b1;
                    end
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end

    // Next address: predicted target, or step past the group
    always_comb begin
        if (grp_taken) begin
            grp_next_pc = pred_target;
        end else begin
            grp_next_pc = fetch_pc + (XLEN'(grp_size) << OFF_W);
        end
    end

    // Extract each lane's word and address from the line
    for (genvar g = 0; g < FETCH_W; g++) begin : g_lane
        logic [SLOT_W-1:0] lslot;
        assign lslot        = slot + SLOT_W'(g);
        assign lane_word[g] = blk_data[int'(lslot) * XLEN +: XLEN];
        assign lane_pc[g]   = fetch_pc + XLEN'(g << OFF_W);
    end
endmodule

// File: rtl/fa_insn_queue.sv
// Circular instruction queue.
// Writes up to ENQ_W entries and removes up to DEQ_W entries per cycle,
// in order. DEPTH need not be a power of two. The caller must not enqueue
// more than the free space; flush empties the queue and overrides both
// ports. A dequeue request above DEQ_W is treated as DEQ_W.
module fa_insn_queue
    import fa_pkg::*;
#(
    parameter int DEPTH  = 18,
    parameter int ENQ_W  = 4,
    parameter int DEQ_W  = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int ESZ_W = $clog2(ENQ_W + 1),
    localparam int DSZ_W = $clog2(DEQ_W + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic [ESZ_W-1:0]            enq_cnt,
    input  fa_entry_t [ENQ_W-1:0]       enq_data,
    input  logic [DSZ_W-1:0]            deq_req,
    output logic [CNT_W-1:0]            q_count,
    output logic [DEQ_W-1:0]            head_valid,
    output fa_entry_t [DEQ_W-1:0]       head_data
);
    fa_entry_t          mem [DEPTH];
    logic [PTR_W-1:0]   head_ptr;
    logic [PTR_W-1:0]   tail_ptr;
    logic [DSZ_W-1:0]   req_clip;
    logic [CNT_W-1:0]   deq_n;

    // Pointer plus offset, modulo DEPTH
    function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p,
                                                  input int off);
        int s;
        s = int'(p) + off;
        if (s >= DEPTH) s = s - DEPTH;
        return PTR_W'(s);
    endfunction

    // Clip the request to the lane count and to the entries held
    always_comb begin
        req_clip = (deq_req > DSZ_W'(DEQ_W)) ? DSZ_W'(DEQ_W) : deq_req;
        deq_n    = (CNT_W'(req_clip) > q_count) ? q_count : CNT_W'(req_clip);
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            q_count  <= '0;
        end else begin
            head_ptr <= wrap_add(head_ptr, int'(deq_n));
            tail_ptr <= wrap_add(tail_ptr, int'(enq_cnt));
            q_count  <= q_count - deq_n + CNT_W'(enq_cnt);
        end
    end

    // Store accepted entries at consecutive tail positions
    always_ff @(posedge clk) begin
        for (int k = 0; k < ENQ_W; k++) begin
            if (ESZ_W'(k) < enq_cnt) begin
                mem[wrap_add(tail_ptr, k)] <= enq_data[k];
            end
        end
    end

    // Present the head lanes
    for (genvar j = 0; j < DEQ_W; j++) begin : g_head
        assign head_valid[j] = (q_count > CNT_W'(j));
        assign head_data[j]  = mem[wrap_add(head_ptr, j)];
    end
endmodule

// File: rtl/fetch_align_queue.sv
// Fetch aligner with decoupling queue (top).
// Holds the fetch address, picks this cycle's group from the presented
// cache line and queues it when it fits whole. A redirect wins over the
// enqueue: it flushes the queue and loads the corrected address.
// Assumes the cache line on blk_data always matches fetch_pc.
module fetch_align_queue
    import fa_pkg::*;
#(
    parameter int XLEN              = fa_pkg::FA_XLEN,
    parameter int BLK_SLOTS         = 16,
    parameter int FETCH_W           = 4,
    parameter int QDEPTH            = 18,
    parameter int DEQ_W             = 2,
    parameter logic [31:0] RESET_PC = 32'h0,
    localparam int SZ_W             = $clog2(FETCH_W + 1),
    localparam int DSZ_W            = $clog2(DEQ_W + 1),
    localparam int CNT_W            = $clog2(QDEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [BLK_SLOTS*XLEN-1:0]     blk_data,
    input  logic [BLK_SLOTS-1:0]          pred_taken,
    input  logic [XLEN-1:0]               pred_target,
    input  logic                          redirect_valid,
    input  logic [XLEN-1:0]               redirect_pc,
    input  logic [DSZ_W-1:0]              deq_req,
    output logic [XLEN-1:0]               fetch_pc,
    output logic [DEQ_W-1:0]              dq_valid,
    output logic [DEQ_W-1:0][XLEN-1:0]    dq_word,
    output logic [DEQ_W-1:0][XLEN-1:0]    dq_pc
);
    logic [SZ_W-1:0]                 grp_size;
    logic                            grp_taken;
    logic [XLEN-1:0]                 grp_next_pc;
    logic [FETCH_W-1:0][XLEN-1:0]    lane_word;
    logic [FETCH_W-1:0][XLEN-1:0]    lane_pc;
    logic [CNT_W-1:0]                q_count;
    logic [CNT_W-1:0]                q_free;
    logic                            grp_fits;
    logic                            enq_ok;
    logic [SZ_W-1:0]                 enq_cnt;
    fa_entry_t [FETCH_W-1:0]         enq_data;
    fa_entry_t [DEQ_W-1:0]           head_data;

    fa_group_select #(
        .XLEN      (XLEN),
        .BLK_SLOTS (BLK_SLOTS),
        .FETCH_W   (FETCH_W)
    ) u_group_select (
        .fetch_pc    (fetch_pc),
        .blk_data    (blk_data),
        .pred_taken  (pred_taken),
        .pred_target (pred_target),
        .grp_size    (grp_size),
        .grp_taken   (grp_taken),
        .grp_next_pc (grp_next_pc),
        .lane_word   (lane_word),
        .lane_pc     (lane_pc)
    );

    // Accept the group only whole, and never alongside a redirect
    always_comb begin
        q_free   = CNT_W'(QDEPTH) - q_count;
        grp_fits = (CNT_W'(grp_size) <= q_free);
        enq_ok   = grp_fits && !redirect_valid;
        enq_cnt  = enq_ok ? grp_size : '0;
    end

    // Pair each lane's address with its word for the queue
    for (genvar g = 0; g < FETCH_W; g++) begin : g_pack
        assign enq_data[g].pc   = lane_pc[g];
        assign enq_data[g].word = lane_word[g];
    end

    fa_insn_queue #(
        .DEPTH (QDEPTH),
        .ENQ_W (FETCH_W),
        .DEQ_W (DEQ_W)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (redirect_valid),
        .enq_cnt    (enq_cnt),
        .enq_data   (enq_data),
        .deq_req    (deq_req),
        .q_count    (q_count),
        .head_valid (dq_valid),
        .head_data  (head_data)
    );

    // Fetch address: redirect, advance on accept, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_pc <= XLEN'(RESET_PC);
        end else if (redirect_valid) begin
            fetch_pc <= redirect_pc;
        end else if (enq_ok) begin
            fetch_pc <= grp_next_pc;
        end
    end

    // Split head entries onto the decode lanes
    for (genvar j = 0; j < DEQ_W; j++) begin : g_out
        assign dq_word[j] = head_data[j].word;
        assign dq_pc[j]   = head_data[j].pc;
    end
endmodule

// File: rtl/fa_checker.sv
// Protocol checker for fetch_align_queue, attached by bind.
// Observes the ports plus queue occupancy and the group selection outputs.
module fa_checker #(
    parameter int XLEN              = 32,
    parameter int BLK_SLOTS         = 16,
    parameter int FETCH_W           = 4,
    parameter int QDEPTH            = 18,
    parameter int DEQ_W             = 2,
    parameter logic [31:0] RESET_PC = 32'h0,
    localparam int SZ_W             = $clog2(FETCH_W + 1),
    localparam int CNT_W            = $clog2(QDEPTH + 1),
    localparam int SLOT_W           = $clog2(BLK_SLOTS),
    localparam int OFF_W            = $clog2(XLEN / 8)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              redirect_valid,
    input logic [XLEN-1:0]   redirect_pc,
    input logic [XLEN-1:0]   pred_target,
    input logic [XLEN-1:0]   fetch_pc,
    input logic [DEQ_W-1:0]  dq_valid,
    input logic [CNT_W-1:0]  q_count,
    input logic [SZ_W-1:0]   grp_size,
    input logic              grp_taken
);
    logic fits;
    logic [SLOT_W:0] room;
    assign fits = (CNT_W'(grp_size) <= (CNT_W'(QDEPTH) - q_count));
    assign room = (SLOT_W + 1)'(BLK_SLOTS) - {1'b0, fetch_pc[OFF_W +: SLOT_W]};

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fetch_pc == XLEN'(RESET_PC)) && (dq_valid == '0));

    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && !grp_taken && fits) |=>
        fetch_pc == $past(fetch_pc) + (XLEN'($past(grp_size)) << OFF_W));

    assert_group_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_size != '0) && ((SLOT_W + 1)'(grp_size) <= room));

    assert_taken_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && grp_taken && fits) |=> fetch_pc == $past(pred_target));

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && !fits) |=> $stable(fetch_pc));

    assert_lane_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid & (dq_valid + 1'b1)) == '0);

    assert_redirect_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (fetch_pc == $past(redirect_pc)) && (dq_valid == '0));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(QDEPTH));
endmodule

bind fetch_align_queue fa_checker #(
    .XLEN      (XLEN),
    .BLK_SLOTS (BLK_SLOTS),
    .FETCH_W   (FETCH_W),
    .QDEPTH    (QDEPTH),
    .DEQ_W     (DEQ_W),
    .RESET_PC  (RESET_PC)
) u_fa_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .pred_target    (pred_target),
    .fetch_pc       (fetch_pc),
    .dq_valid       (dq_valid),
    .q_count        (q_count),
    .grp_size       (grp_size),
    .grp_taken      (grp_taken)
);

// File: tb/fetch_align_queue_bench.sv
`timescale 1ns/1ps
module fetch_align_queue_bench;
    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [511:0]         blk_data = '0;
    logic [15:0]          pred_taken = '0;
    logic [31:0]          pred_target = '0;
    logic                 redirect_valid = 1'b0;
    logic [31:0]          redirect_pc = '0;
    logic [1:0]           deq_req = '0;
    logic [31:0]          fetch_pc;
    logic [1:0]           dq_valid;
    logic [1:0][31:0]     dq_word;
    logic [1:0][31:0]     dq_pc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model state
    logic [31:0] mpc;
    logic [31:0] mq_pc[$];
    logic [31:0] mq_w[$];

    always #2.5 clk = ~clk;

    fetch_align_queue u_fetch_align_queue (
        .clk(clk), .rst_n(rst_n), .blk_data(blk_data), .pred_taken(pred_taken),
        .pred_target(pred_target), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .deq_req(deq_req), .fetch_pc(fetch_pc),
        .dq_valid(dq_valid), .dq_word(dq_word), .dq_pc(dq_pc)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[17:2]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every output with the model
    task automatic compare(input string req);
        int occ;
        occ = mq_pc.size();
        chk(fetch_pc == mpc, req, "fetch_pc", fetch_pc, mpc);
        for (int i = 0; i < 2; i++) begin
            chk(dq_valid[i] == (occ > i), "R6", "dq_valid", 32'(dq_valid[i]), 32'(occ > i));
            if (occ > i) begin
                chk(dq_pc[i] == mq_pc[i], "R6", "dq_pc", dq_pc[i], mq_pc[i]);
                chk(dq_word[i] == mq_w[i], "R6", "dq_word", dq_word[i], mq_w[i]);
            end
        end
    endtask

    // One cycle: drive, advance model, clock, compare
    task automatic step(input bit rv, input logic [31:0] rpc, input logic [15:0] tk,
                        input logic [31:0] tg, input logic [1:0] dq);
        int occ, n, slot, gsz;
        bit tkn, fits;
        string tag;
        for (int s = 0; s < 16; s++)
            blk_data[s*32 +: 32] = word_of({mpc[31:6], 6'b0} + 32'(s * 4));
        redirect_valid = rv; redirect_pc = rpc; pred_taken = tk;
        pred_target = tg; deq_req = dq;
        occ = mq_pc.size();
        if (rv) begin
            mq_pc.delete(); mq_w.delete();
            mpc = rpc; tag = "R7";
        end else begin
            n = (dq > 2) ? 2 : int'(dq);
            if (n > occ) n = occ;
            slot = int'(mpc[5:2]); gsz = 0; tkn = 1'b0;
            for (int i = 0; i < 4; i++) begin
                if (slot + i > 15) break;
                gsz = i + 1;
                if (tk[slot + i]) begin tkn = 1'b1; break; end
            end
            fits = (gsz <= 18 - occ);
            for (int i = 0; i < n; i++) begin
                void'(mq_pc.pop_front()); void'(mq_w.pop_front());
            end
            if (fits) begin
                for (int i = 0; i < gsz; i++) begin
                    mq_pc.push_back(mpc + 32'(4 * i));
                    mq_w.push_back(word_of(mpc + 32'(4 * i)));
                end
                mpc = tkn ? tg : mpc + 32'(4 * gsz);
            end
            if (!fits) tag = "R5";
            else if (tkn) tag = "R4";
            else if (gsz < 4) tag = "R3";
            else tag = "R2";
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mpc = 32'h0;
        chk(fetch_pc == 32'h0, "R1", "reset fetch_pc", fetch_pc, 32'h0);
        chk(dq_valid == 2'b00, "R1", "reset dq_valid", 32'(dq_valid), 32'h0);

        // R2: sequential full groups, decode draining two per cycle
        for (int c = 0; c < 6; c++) step(1'b0, 0, 16'h0, 0, 2'd2);
        chk(fetch_pc == 32'h60, "R2", "pc after six groups", fetch_pc, 32'h60);

        // R8/R3/R5: fill to exactly 18 from slot 2 with decode idle
        step(1'b1, 32'h108, 16'h0, 0, 2'd0);
        for (int c = 0; c < 5; c++) step(1'b0, 0, 16'h0, 0, 2'd0);
        chk(fetch_pc == 32'h150, "R8", "pc after 18 entries", fetch_pc, 32'h150);
        chk(dq_pc[0] == 32'h108, "R8", "oldest entry", dq_pc[0], 32'h108);
        for (int c = 0; c < 3; c++) step(1'b0, 0, 16'h0, 0, 2'd0);
        chk(fetch_pc == 32'h150, "R5", "pc held while full", fetch_pc, 32'h150);
        step(1'b0, 0, 16'h0, 0, 2'd3);
        chk(dq_pc[0] == 32'h110, "R6", "request 3 acts as 2", dq_pc[0], 32'h110);

        // R3: single instruction at slot 15
        step(1'b1, 32'h23C, 16'h0, 0, 2'd0);
        step(1'b0, 0, 16'h0, 0, 2'd0);
        chk(fetch_pc == 32'h240, "R3", "slot 15 group of one", fetch_pc, 32'h240);

        // R4: taken slot ends group, flags behind or beyond ignored
        step(1'b1, 32'h200, 16'h0, 0, 2'd2);
        step(1'b0, 0, 16'h0004, 32'h30C, 2'd2);
        chk(fetch_pc == 32'h30C, "R4", "taken at slot 2", fetch_pc, 32'h30C);
        step(1'b0, 0, 16'h0009, 32'h3C0, 2'd2);
        chk(fetch_pc == 32'h3C0, "R4", "taken at fetch slot", fetch_pc, 32'h3C0);
        step(1'b0, 0, 16'h0200, 32'h500, 2'd2);
        chk(fetch_pc == 32'h3D0, "R4", "flag outside window", fetch_pc, 32'h3D0);

        // R7: redirect while queue busy
        step(1'b1, 32'h840, 16'h0, 0, 2'd2);
        chk(dq_valid == 2'b00, "R7", "flushed", 32'(dq_valid), 32'h0);

        // Random mix of everything
        for (int c = 0; c < 3000; c++) begin
            step(($urandom % 32) == 0, {20'h0, 10'($urandom), 2'b00},
                 16'($urandom & $urandom & $urandom),
                 {20'h0, 10'($urandom), 2'b00}, 2'($urandom));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule